// File: doc/BRIEF.md
# Reset and clock-release sequencer

This block decides when a chip leaves reset and when its system clock may run. It takes a set of reset requests and the code of the selected clock source, and drives two results: a reset-release flag and a clock enable. Each kind of request runs its own chain of timed phases, and each phase length is a parameter counted on the free-running reference clock `clk_i`.

The longest chain belongs to power-on, which includes the deassertion of `rst_ni`. Brown-out drops the first phase of that chain. The six short-path causes (external pin, watchdog, software, illegal opcode, uninitialized register, trap conflict) run only the final phase. Only a power-on or brown-out start holds back the clock. At that point the block samples the source code and the two-speed option, then holds `clk_en_o` low until that source's own qualifiers are met. Those qualifiers are an oscillator start-up count, PLL lock, and RC ready.

With two-speed start-up, the clock runs on the fast RC until the primary source is ready. A sticky cause register records every request that arrives.

Top module: `rst_clk_seq`

## Requirements
- R1: After `rst_ni` deasserts, or after a cycle with `por_req_i` high, `rst_release_o` rises exactly POR_CYC+VREG_CYC+IRST_CYC cycles later. This covers a power-on delay, then a regulator delay, then an internal reset time.
- R2: A cycle with `bor_req_i` high, outside the power-on phase, releases reset exactly VREG_CYC+IRST_CYC cycles later.
- R3: A cycle with any bit of `short_req_i` high, while reset is released, releases reset again exactly IRST_CYC cycles later. During that time `clk_en_o` and `osc_en_o` do not change.
- R4: While any request is present, `rst_release_o` is low. A request restarts the chain at its own first phase only if that phase is not later than the current one, with priority power-on > brown-out > short. A request whose first phase is later than the current phase is absorbed, and the chain runs on unchanged.
- R5: `cause_o` bits are: [0] power-on (also set by `rst_ni`), [1] brown-out, [7:2] = `short_req_i[5:0]`. Each bit is sticky until a cycle with `cause_clr_i` high. In the same cycle, setting a bit wins over clearing it. The reset value is 8'h01.
- R6: `clk_src_i` codes and their wait conditions:
  - 0: external clock, no wait.
  - 1: external clock with PLL, waits for lock.
  - 2: crystal, waits for the start-up count.
  - 3: crystal with PLL, waits for the count, then lock.
  - 4: fast RC, waits for RC ready.
  - 5: fast RC with PLL, waits for RC ready, then lock.
  - 6: low-power RC, waits for RC ready.
  - 7: behaves as 0.

  `clk_en_o` falls only at a power-on or brown-out start and rises when these conditions are met.
- R7: `osc_en_o` is high for codes 2 and 3, except in the cycle after a power-on or brown-out start. The start-up counter clears while `osc_en_o` is low. It counts rising edges of the asynchronous `osc_i` after a SYNC_STAGES-flop synchronizer, and completes on edge OST_EDGES (default 1024).
- R8: `pll_lock_i` is considered only after the source condition has been met. Lock alone never releases a crystal or RC source. `pll_lock_i` and `rc_ready_i` are synchronous to `clk_i`.
- R9: With two-speed sampled high and a primary code (0 to 3), `clk_en_o` rises once `rc_ready_i` is high, with `clk_frc_o` high. When the primary conditions are met, `clk_frc_o` falls and `clk_en_o` stays high. For RC codes (4 to 6), `clk_frc_o` stays low.
- R10: The source code and the two-speed option are sampled only at a power-on or brown-out start. Later changes to either input, and short-path requests, do not affect the running clock qualification.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset; release starts a power-on chain |
| por_req_i | input | 1 | Power-on request |
| bor_req_i | input | 1 | Brown-out request |
| short_req_i | input | 6 | Short-path requests: pin, watchdog, software, illegal opcode, uninitialized register, trap conflict |
| clk_src_i | input | 3 | Selected clock-source code |
| two_speed_i | input | 1 | Two-speed start-up enable |
| osc_i | input | 1 | Raw oscillator signal, asynchronous |
| pll_lock_i | input | 1 | PLL locked |
| rc_ready_i | input | 1 | Internal RC oscillator running |
| cause_clr_i | input | 1 | Clear strobe for the cause register |
| rst_release_o | output | 1 | System reset released |
| clk_en_o | output | 1 | System clock enabled |
| clk_frc_o | output | 1 | Clock currently taken from the fast RC (two-speed) |
| osc_en_o | output | 1 | Oscillator enable; low clears the start-up count |
| cause_o | output | 8 | Sticky reset-cause bits |

## Verification
The hardest situation to reach is a start-up count that is interrupted partway and then has to restart from zero. The bench drives 500 oscillator edges and then issues a fresh power-on. It then checks that 1023 further edges leave the clock held and that the 1024th releases it, with lock already high throughout.

Absorbed requests are the next hard case. The bench reaches them by timing a brown-out into the power-on phase and a short request into the regulator phase. It then confirms that the total release time is unchanged. A brown-out placed in the last phase must still restart the chain.

// File: rtl/rcs_pkg.sv
package rcs_pkg;
  localparam int unsigned NUM_SHORT = 6;
  localparam int unsigned CAUSE_W   = NUM_SHORT + 2;

  typedef enum logic [1:0] {
    PH_POR  = 2'd0,
    PH_VREG = 2'd1,
    PH_IRST = 2'd2,
    PH_DONE = 2'd3
  } phase_e;

  typedef enum logic [2:0] {
    SRC_EXT      = 3'd0,
    SRC_EXT_PLL  = 3'd1,
    SRC_XTAL     = 3'd2,
    SRC_XTAL_PLL = 3'd3,
    SRC_FRC      = 3'd4,
    SRC_FRC_PLL  = 3'd5,
    SRC_LPRC     = 3'd6,
    SRC_RSVD     = 3'd7
  } src_e;

  function automatic logic needs_ost(src_e s);
    return s inside {SRC_XTAL, SRC_XTAL_PLL};
  endfunction

  function automatic logic needs_rc(src_e s);
    return s inside {SRC_FRC, SRC_FRC_PLL, SRC_LPRC};
  endfunction

  function automatic logic needs_lock(src_e s);
    return s inside {SRC_EXT_PLL, SRC_XTAL_PLL, SRC_FRC_PLL};
  endfunction
endpackage

// File: rtl/rcs_phase_seq.sv
module rcs_phase_seq
  import rcs_pkg::*;
#(
  parameter int unsigned POR_CYC  = 2000,
  parameter int unsigned VREG_CYC = 200,
  parameter int unsigned IRST_CYC = 400
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic por_i,
  input  logic bor_i,
  input  logic short_i,
  output logic release_o,
  output logic long_start_o
);
  localparam int unsigned MAX_A = (POR_CYC > VREG_CYC) ? POR_CYC : VREG_CYC;
  localparam int unsigned MAX_C = (MAX_A > IRST_CYC) ? MAX_A : IRST_CYC;
  localparam int unsigned CW    = $clog2(MAX_C + 1);

  phase_e          st_q, st_d, req_ph;
  logic [CW-1:0]   cnt_q, cnt_d, last_cnt;
  logic            first_q, req;

  always_comb begin
    case (st_q)
      PH_POR:  last_cnt = CW'(POR_CYC - 1);
      PH_VREG: last_cnt = CW'(VREG_CYC - 1);
      PH_IRST: last_cnt = CW'(IRST_CYC - 1);
      default: last_cnt = '0;
    endcase
  end

  assign req    = por_i | bor_i | short_i;
  assign req_ph = por_i ? PH_POR : (bor_i ? PH_VREG : PH_IRST);

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    if (req && (req_ph <= st_q)) begin
      // restart only if it does not shorten the chain in progress
      st_d  = req_ph;
      cnt_d = '0;
    end else if (st_q != PH_DONE) begin
      if (cnt_q == last_cnt) begin
        st_d  = phase_e'(st_q + 2'd1);
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= PH_POR;
      cnt_q   <= '0;
      first_q <= 1'b1;
    end else begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      first_q <= 1'b0;
    end
  end

  assign release_o    = (st_q == PH_DONE);
  assign long_start_o = first_q | por_i | bor_i;

  // R1
  por_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    por_i |=> (st_q == PH_POR) && (cnt_q == '0));
  // R2
  bor_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bor_i && !por_i && st_q != PH_POR) |=> (st_q == PH_VREG) && (cnt_q == '0));
  // R3
  release_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(release_o) |-> ($past(st_q) == PH_IRST));
  // R4
  req_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req |=> !release_o);
endmodule

// File: rtl/rcs_ost.sv
module rcs_ost #(
  parameter int unsigned EDGES = 1024,
  parameter int unsigned SYNC  = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic osc_i,
  output logic done_o
);
  localparam int unsigned CW = $clog2(EDGES);

  logic [SYNC-1:0] sync_q;
  logic            prev_q, done_q, rise;
  logic [CW-1:0]   cnt_q;

  for (genvar g = 0; g < SYNC; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q[g] <= 1'b0;
        else         sync_q[g] <= osc_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q[g] <= 1'b0;
        else         sync_q[g] <= sync_q[g-1];
      end
    end
  end

  assign rise = sync_q[SYNC-1] & ~prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      prev_q <= sync_q[SYNC-1];
      if (!en_i) begin
        cnt_q  <= '0;
        done_q <= 1'b0;
      end else if (rise && !done_q) begin
        if (cnt_q == CW'(EDGES - 1)) done_q <= 1'b1;
        else                         cnt_q  <= cnt_q + 1'b1;
      end
    end
  end

  assign done_o = done_q;

  // R7
  ost_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (cnt_q == '0) && !done_o);
  // R7
  ost_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_q) |-> ($past(cnt_q) == CW'(EDGES - 1)) && $past(rise));
endmodule

// File: rtl/rcs_clk_qual.sv
module rcs_clk_qual
  import rcs_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic long_start_i,
  input  src_e src_i,
  input  logic two_speed_i,
  input  logic ost_done_i,
  input  logic pll_lock_i,
  input  logic rc_ready_i,
  output logic clk_en_o,
  output logic clk_frc_o,
  output logic osc_en_o
);
  src_e src_q;
  logic ts_q, src_done_q, prim_done_q, frc_done_q, osc_en_q, src_ok;

  always_comb begin
    if (needs_ost(src_q))     src_ok = ost_done_i & osc_en_q;
    else if (needs_rc(src_q)) src_ok = rc_ready_i;
    else                      src_ok = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q       <= SRC_EXT;
      ts_q        <= 1'b0;
      src_done_q  <= 1'b0;
      prim_done_q <= 1'b0;
      frc_done_q  <= 1'b0;
      osc_en_q    <= 1'b0;
    end else if (long_start_i) begin
      src_q       <= src_i;
      ts_q        <= two_speed_i & ~needs_rc(src_i);
      src_done_q  <= 1'b0;
      prim_done_q <= 1'b0;
      frc_done_q  <= 1'b0;
      osc_en_q    <= 1'b0;
    end else begin
      osc_en_q    <= needs_ost(src_q);
      src_done_q  <= src_done_q | src_ok;
      prim_done_q <= prim_done_q | (src_done_q & (~needs_lock(src_q) | pll_lock_i));
      frc_done_q  <= frc_done_q | (ts_q & rc_ready_i);
    end
  end

  assign clk_en_o  = prim_done_q | frc_done_q;
  assign clk_frc_o = frc_done_q & ~prim_done_q;
  assign osc_en_o  = osc_en_q;

  // R10
  src_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !long_start_i |=> $stable(src_q) && $stable(ts_q));
  // R6
  clk_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_en_o && !long_start_i) |=> clk_en_o);
  // R8
  lock_after_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(prim_done_q) |-> $past(src_done_q) && (!needs_lock(src_q) || $past(pll_lock_i)));
  // R7
  ost_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(src_done_q) && needs_ost(src_q)) |-> $past(ost_done_i));
  // R9
  frc_only_ts_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_frc_o |-> ts_q);
endmodule

// File: rtl/rst_clk_seq.sv
module rst_clk_seq
  import rcs_pkg::*;
#(
  parameter int unsigned POR_CYC     = 2000,
  parameter int unsigned VREG_CYC    = 200,
  parameter int unsigned IRST_CYC    = 400,
  parameter int unsigned OST_EDGES   = 1024,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 por_req_i,
  input  logic                 bor_req_i,
  input  logic [NUM_SHORT-1:0] short_req_i,
  input  logic [2:0]           clk_src_i,
  input  logic                 two_speed_i,
  input  logic                 osc_i,
  input  logic                 pll_lock_i,
  input  logic                 rc_ready_i,
  input  logic                 cause_clr_i,
  output logic                 rst_release_o,
  output logic                 clk_en_o,
  output logic                 clk_frc_o,
  output logic                 osc_en_o,
  output logic [CAUSE_W-1:0]   cause_o
);
  logic               long_start, ost_done;
  logic [CAUSE_W-1:0] req_vec, cause_q;

  rcs_phase_seq #(
    .POR_CYC (POR_CYC),
    .VREG_CYC(VREG_CYC),
    .IRST_CYC(IRST_CYC)
  ) u_phase (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .por_i       (por_req_i),
    .bor_i       (bor_req_i),
    .short_i     (|short_req_i),
    .release_o   (rst_release_o),
    .long_start_o(long_start)
  );

  rcs_ost #(
    .EDGES(OST_EDGES),
    .SYNC (SYNC_STAGES)
  ) u_ost (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (osc_en_o),
    .osc_i (osc_i),
    .done_o(ost_done)
  );

  rcs_clk_qual u_clk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .long_start_i(long_start),
    .src_i       (src_e'(clk_src_i)),
    .two_speed_i (two_speed_i),
    .ost_done_i  (ost_done),
    .pll_lock_i  (pll_lock_i),
    .rc_ready_i  (rc_ready_i),
    .clk_en_o    (clk_en_o),
    .clk_frc_o   (clk_frc_o),
    .osc_en_o    (osc_en_o)
  );

  assign req_vec = {short_req_i, bor_req_i, por_req_i};

  for (genvar i = 0; i < CAUSE_W; i++) begin : g_cause
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         cause_q[i] <= (i == 0);
      else if (req_vec[i]) cause_q[i] <= 1'b1;
      else if (cause_clr_i) cause_q[i] <= 1'b0;
    end
  end

  assign cause_o = cause_q;

  // R5
  cause_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    por_req_i |=> cause_o[0]);
  // R5
  cause_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cause_clr_i && !(|req_vec)) |=> (cause_o == '0));
endmodule

// File: tb/sim_rst_clk_seq.sv
`timescale 1ns/1ps
module sim_rst_clk_seq;
  localparam int P = 12, V = 6, I = 4, FULL = P + V + I;

  logic       clk = 1'b0, rst_ni = 1'b0;
  logic       por_req = 0, bor_req = 0, two_speed = 0, osc = 0, lock = 0, rc_rdy = 0, clr = 0;
  logic [5:0] short_req = '0;
  logic [2:0] src = 3'd0;
  logic       rel, clk_en, clk_frc, osc_en;
  logic [7:0] cause;
  int         checks = 0, fails = 0, elapsed = 0;

  always #2.5 clk = ~clk;

  rst_clk_seq #(.POR_CYC(P), .VREG_CYC(V), .IRST_CYC(I)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .por_req_i(por_req), .bor_req_i(bor_req),
    .short_req_i(short_req), .clk_src_i(src), .two_speed_i(two_speed), .osc_i(osc),
    .pll_lock_i(lock), .rc_ready_i(rc_rdy), .cause_clr_i(clr),
    .rst_release_o(rel), .clk_en_o(clk_en), .clk_frc_o(clk_frc), .osc_en_o(osc_en),
    .cause_o(cause));

  task automatic tick(int n = 1);
    repeat (n) begin @(negedge clk); elapsed++; end
  endtask

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulse_por(); por_req = 1; tick(); por_req = 0; endtask
  task automatic pulse_bor(); bor_req = 1; tick(); bor_req = 0; endtask
  task automatic pulse_short(int k); short_req[k] = 1'b1; tick(); short_req = '0; endtask

  task automatic wait_rel();
    for (int g = 0; g < 500 && !rel; g++) tick();
  endtask

  task automatic osc_edges(int n);
    repeat (n) begin osc = 1; tick(2); osc = 0; tick(2); end
  endtask

  task automatic start_src(logic [2:0] code, logic ts);
    src = code; two_speed = ts; pulse_por(); elapsed = 0;
  endtask

  task automatic t_reset();
    tick(3);
    chk("R1 release low in reset", rel, 0);
    chk("R6 clk_en low in reset", clk_en, 0);
    chk("R5 cause reset value", cause, 8'h01);
    @(negedge clk); rst_ni = 1; elapsed = 0;
    wait_rel();
    chk("R1 power-on length", elapsed, FULL);
    chk("R6 ext clock enabled", clk_en, 1);
    chk("R7 osc_en low for ext", osc_en, 0);
  endtask

  task automatic t_cause();
    clr = 1; tick(); clr = 0; tick();
    chk("R5 clear", cause, 0);
    clr = 1; short_req[0] = 1; tick(); clr = 0; short_req = '0; tick();
    chk("R5 set beats clear", cause, 8'h04);
    wait_rel();
  endtask

  task automatic t_bor();
    clr = 1; tick(); clr = 0;
    pulse_bor(); elapsed = 0; wait_rel();
    chk("R2 brown-out length", elapsed, V + I);
    chk("R5 brown-out cause", cause, 8'h02);
  endtask

  task automatic t_short();
    for (int k = 0; k < 6; k++) begin
      logic dropped;
      dropped = 0;
      clr = 1; tick(); clr = 0;
      pulse_short(k); elapsed = 0;
      for (int g = 0; g < 100 && !rel; g++) begin tick(); if (!clk_en || osc_en) dropped = 1; end
      chk("R3 short length", elapsed, I);
      chk("R3 clock untouched", dropped, 0);
      chk("R5 short cause bit", cause, 1 << (k + 2));
    end
  endtask

  task automatic t_restart();
    logic seen;
    pulse_por(); elapsed = 0; tick(5); pulse_bor(); wait_rel();
    chk("R4 bor absorbed in POR phase", elapsed, FULL);
    pulse_por(); elapsed = 0; tick(15); pulse_por(); wait_rel();
    chk("R4 por restarts chain", elapsed, 16 + FULL);
    pulse_por(); elapsed = 0; tick(14); pulse_short(3); wait_rel();
    chk("R4 short absorbed in VREG phase", elapsed, FULL);
    pulse_por(); elapsed = 0; tick(19); pulse_bor(); wait_rel();
    chk("R4 bor restarts from IRST phase", elapsed, 20 + V + I);
    seen = 0;
    por_req = 1;
    for (int g = 0; g < 10; g++) begin tick(); if (rel) seen = 1; end
    por_req = 0; elapsed = 0;
    chk("R4 held request keeps reset", seen, 0);
    wait_rel();
    chk("R4 length after held request", elapsed, FULL);
  endtask

  task automatic t_src();
    lock = 0; rc_rdy = 0;
    start_src(3'd1, 0); tick(3);
    chk("R6 ext+pll waits lock", clk_en, 0);
    lock = 1; tick(3);
    chk("R6 ext+pll released", clk_en, 1);
    lock = 0;
    start_src(3'd4, 0); tick(3);
    chk("R6 frc waits ready", clk_en, 0);
    rc_rdy = 1; tick(3);
    chk("R6 frc released", clk_en, 1);
    rc_rdy = 0; lock = 1;
    start_src(3'd5, 0); tick(4);
    chk("R8 lock alone insufficient", clk_en, 0);
    lock = 0; rc_rdy = 1; tick(4);
    chk("R8 ready without lock", clk_en, 0);
    lock = 1; tick(3);
    chk("R8 frc+pll released", clk_en, 1);
    lock = 0; rc_rdy = 0;
    start_src(3'd6, 0); tick(3);
    chk("R6 lprc waits ready", clk_en, 0);
    rc_rdy = 1; tick(3);
    chk("R6 lprc released", clk_en, 1);
    rc_rdy = 0;
    start_src(3'd7, 0); tick(3);
    chk("R6 code 7 as ext", clk_en, 1);
    chk("R7 osc_en low for code 7", osc_en, 0);
    wait_rel();
  endtask

  task automatic t_ost();
    lock = 1; rc_rdy = 0;
    start_src(3'd3, 0); tick(3);
    chk("R7 osc_en high for crystal", osc_en, 1);
    osc_edges(500);
    start_src(3'd3, 0); tick(3);
    osc_edges(1023); tick(8);
    chk("R7 count restarted, 1023 edges hold", clk_en, 0);
    osc_edges(1); tick(8);
    chk("R7 1024th edge releases", clk_en, 1);
    lock = 0;
    start_src(3'd2, 0); tick(3);
    osc_edges(1024); tick(8);
    chk("R7 crystal without pll released", clk_en, 1);
    wait_rel();
  endtask

  task automatic t_two_speed();
    lock = 0; rc_rdy = 0;
    start_src(3'd2, 1); tick(3);
    chk("R9 waits for rc", clk_en, 0);
    rc_rdy = 1; tick(3);
    chk("R9 runs early", clk_en, 1);
    chk("R9 on fast rc", clk_frc, 1);
    osc_edges(1024); tick(8);
    chk("R9 switched to primary", clk_frc, 0);
    chk("R9 clock kept", clk_en, 1);
    start_src(3'd4, 1); tick(4);
    chk("R9 rc source ignores two-speed", clk_frc, 0);
    rc_rdy = 0; two_speed = 0;
    wait_rel();
  endtask

  task automatic t_sample();
    rc_rdy = 0;
    start_src(3'd4, 0); tick(2);
    src = 3'd0; two_speed = 1; tick(4);
    chk("R10 later code ignored", clk_en, 0);
    chk("R10 later two-speed ignored", clk_frc, 0);
    rc_rdy = 1; tick(3);
    chk("R10 sampled code honored", clk_en, 1);
    wait_rel();
    src = 3'd2; pulse_short(1); tick(6);
    chk("R10 short keeps clock", clk_en, 1);
    chk("R10 short no resample", osc_en, 0);
    two_speed = 0;
  endtask

  initial begin
    t_reset();
    t_cause();
    t_bor();
    t_short();
    t_restart();
    t_src();
    t_ost();
    t_two_speed();
    t_sample();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog R1: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule